// File: doc/BRIEF.md
# Fixed-Cycle Countdown Timer

This block generates a repeating event from a 12-bit programmable down-counter. The counter is clocked by one of four slow rates. A divider elsewhere on the chip supplies these rates as one-cycle enable strobes. The host supplies the count as an 8-bit low part and a 4-bit high part. It also supplies a two-bit rate select, a run enable and an interrupt enable. Once the run enable rises, the preset is loaded. Every selected strobe then moves the count down by one.

When the count expires, the counter reloads the preset and keeps running. A sticky expiry flag is set, and it stays set until the host clears it. If the interrupt is enabled, an active-low interrupt line is also driven low. The line releases itself after a hold time that depends on the rate. For the fastest rate, it releases at the next 8192 Hz strobe, which is half of one source period. For the other rates, it releases after 64 of those strobes, about 7.8 ms. The flag is unaffected by the release.

Top module: `fixed_cycle_timer`

## Requirements
- R1: While reset is high and on the cycle after it, expiry_flag reads 0 and irq_n reads 1.
- R2: The period is the 12-bit value {preset_hi, preset_lo}. preset_hi carries weights 2048..256 and preset_lo carries weights 128..1. An expiry follows exactly that many selected strobes after the count is loaded.
- R3: src_sel picks bit src_sel of src_stb as the counting strobe, with 0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz and 3 = once per minute. Strobes on other bits do not advance the count.
- R4: While run_en is 0, strobes have no effect and no expiry occurs.
- R5: In the cycle run_en goes from 0 to 1, the count loads the preset. A strobe in that same cycle is not counted.
- R6: After an expiry, the count reloads the preset and keeps running, so further expiries follow every preset strobes.
- R7: A preset of 0 never produces an expiry.
- R8: An expiry sets expiry_flag one cycle after the counting strobe. The flag stays at 1 until a flag_clr pulse. If an expiry and flag_clr coincide, the flag is set.
- R9: With irq_en at 1, irq_n goes low in the same cycle that expiry_flag is set.
- R10: With irq_en at 0, irq_n stays 1 while the flag is still set. Dropping irq_en while irq_n is low releases the line on the next cycle.
- R11: With src_sel = 0, irq_n returns to 1 on the first half_stb after it went low. With any other src_sel, it returns to 1 on the 64th half_stb. Without half_stb, irq_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_stb | input | 4 | Rate strobes; bit i is the rate with code i |
| half_stb | input | 1 | 8192 Hz strobe that times the interrupt hold |
| preset_lo | input | 8 | Low part of the period, weights 128..1 |
| preset_hi | input | 4 | High part of the period, weights 2048..256 |
| src_sel | input | 2 | Counting rate select |
| run_en | input | 1 | Counter enable; a rising edge loads the preset |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle host clear of the expiry flag |
| expiry_flag | output | 1 | Sticky expiry flag |
| irq_n | output | 1 | Active-low self-releasing interrupt |

## Verification
The period is measured under several patterns: random short presets on random rates, with strobes of the other rates mixed in between; a preset with a nonzero high part; and a preset of zero. Together they separate a correct strobe selection and a correct 12-bit width from a wrong select decode or a dropped high nibble. Further directed patterns cover a strobe that coincides with the start of counting and a clear that coincides with an expiry. These show whether the load and the set take their intended priority. The interrupt line is observed with both hold lengths, with the enable off, and with the enable dropped mid-pulse, which tells the fast and slow release paths apart.

// File: rtl/fct_pkg.sv
package fct_pkg;
  typedef enum logic [1:0] {
    SRC_4K  = 2'd0,
    SRC_64  = 2'd1,
    SRC_1S  = 2'd2,
    SRC_1M  = 2'd3
  } src_rate_e;
endpackage

// File: rtl/fct_src_mux.sv
module fct_src_mux #(
  parameter int SEL_W = 2,
  localparam int NUM_SRC = 1 << SEL_W
) (
  input  logic [NUM_SRC-1:0] src_stb,
  input  logic [SEL_W-1:0]   src_sel,
  output logic               tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel == SEL_W'(i)) tick = src_stb[i];
    end
  end
endmodule

// File: rtl/fct_down_counter.sv
module fct_down_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             tick,
  input  logic [CNT_W-1:0] preset,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      en_q   <= 1'b0;
      expire <= 1'b0;
    end else begin
      en_q   <= run_en;
      expire <= 1'b0;
      if (run_en && !en_q) begin
        cnt <= preset;
      end else if (run_en && tick) begin
        if (preset == '0) begin
          cnt <= '0;
        end else if (cnt == CNT_W'(1)) begin
          expire <= 1'b1;
          cnt    <= preset;
        end else if (cnt == '0) begin
          cnt <= preset;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  // R4
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !expire);

  // R7
  zero_preset_chk: assert property (@(posedge clk) disable iff (rst)
    (preset == '0) |=> !expire);

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire |-> (cnt == $past(preset)));

  // R5
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |=> !expire);
endmodule

// File: rtl/fct_irq_ctl.sv
module fct_irq_ctl #(
  parameter int SEL_W      = 2,
  parameter int SHORT_HOLD = 1,
  parameter int LONG_HOLD  = 64,
  localparam int HOLD_W    = $clog2(LONG_HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             half_stb,
  input  logic [SEL_W-1:0] src_sel,
  output logic             flag,
  output logic             irq_n
);
  import fct_pkg::*;

  logic [HOLD_W-1:0] hold;
  logic              fast_src;

  assign fast_src = (src_sel == SEL_W'(SRC_4K));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (expire) begin
      flag <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
      hold  <= '0;
    end else if (!irq_en) begin
      irq_n <= 1'b1;
      hold  <= '0;
    end else if (expire) begin
      irq_n <= 1'b0;
      hold  <= fast_src ? HOLD_W'(SHORT_HOLD) : HOLD_W'(LONG_HOLD);
    end else if (!irq_n && half_stb) begin
      if (hold <= HOLD_W'(1)) begin
        irq_n <= 1'b1;
        hold  <= '0;
      end else begin
        hold <= hold - HOLD_W'(1);
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_n && !flag));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  // R9
  irq_assert_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && irq_en) |=> (!irq_n && flag));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> irq_n);

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && irq_en && !half_stb) |=> !irq_n);
endmodule

// File: rtl/fixed_cycle_timer.sv
module fixed_cycle_timer #(
  parameter int LO_W       = 8,
  parameter int HI_W       = 4,
  parameter int SEL_W      = 2,
  parameter int SHORT_HOLD = 1,
  parameter int LONG_HOLD  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [(1 << SEL_W)-1:0]  src_stb,
  input  logic                     half_stb,
  input  logic [LO_W-1:0]          preset_lo,
  input  logic [HI_W-1:0]          preset_hi,
  input  logic [SEL_W-1:0]         src_sel,
  input  logic                     run_en,
  input  logic                     irq_en,
  input  logic                     flag_clr,
  output logic                     expiry_flag,
  output logic                     irq_n
);
  localparam int CNT_W = LO_W + HI_W;

  logic             tick;
  logic             expire;
  logic [CNT_W-1:0] preset;

  assign preset = {preset_hi, preset_lo};

  fct_src_mux #(.SEL_W(SEL_W)) u_mux (
    .src_stb (src_stb),
    .src_sel (src_sel),
    .tick    (tick)
  );

  fct_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .tick   (tick),
    .preset (preset),
    .expire (expire)
  );

  fct_irq_ctl #(
    .SEL_W      (SEL_W),
    .SHORT_HOLD (SHORT_HOLD),
    .LONG_HOLD  (LONG_HOLD)
  ) u_irq (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire),
    .irq_en   (irq_en),
    .flag_clr (flag_clr),
    .half_stb (half_stb),
    .src_sel  (src_sel),
    .flag     (expiry_flag),
    .irq_n    (irq_n)
  );
endmodule

// File: tb/sim_fixed_cycle_timer.sv
`timescale 1ns/1ps
module sim_fixed_cycle_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src_stb = '0;
  logic       half_stb = 1'b0;
  logic [7:0] preset_lo = '0;
  logic [3:0] preset_hi = '0;
  logic [1:0] src_sel = '0;
  logic       run_en = 1'b0;
  logic       irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       expiry_flag;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fixed_cycle_timer u0 (
    .clk(clk), .rst(rst), .src_stb(src_stb), .half_stb(half_stb),
    .preset_lo(preset_lo), .preset_hi(preset_hi), .src_sel(src_sel),
    .run_en(run_en), .irq_en(irq_en), .flag_clr(flag_clr),
    .expiry_flag(expiry_flag), .irq_n(irq_n)
  );

  function automatic int exp_period(input logic [3:0] hi, input logic [7:0] lo);
    return int'(hi) * 256 + int'(lo);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_src(input int idx);
    src_stb[idx] = 1'b1;
    @(negedge clk);
    src_stb = '0;
  endtask

  task automatic pulse_half();
    half_stb = 1'b1;
    @(negedge clk);
    half_stb = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic restart();
    run_en = 1'b0;
    cyc(1);
    clear_flag();
    run_en = 1'b1;
    cyc(1);
  endtask

  // count selected strobes until the flag rises; noise adds other strobes
  task automatic measure(input int sel, input int limit, input bit noise, output int got);
    got = 0;
    for (int t = 1; t <= limit; t++) begin
      if (noise) begin
        int other;
        other = (sel + 1 + int'($urandom_range(0, 2))) % 4;
        pulse_src(other);
      end
      pulse_src(sel);
      cyc(1);
      if (expiry_flag) begin
        got = t;
        break;
      end
    end
  endtask

  initial begin
    int got;
    void'($urandom(32'h5EED_1234));
    cyc(1);
    // R1 during reset
    check(expiry_flag == 1'b0 && irq_n == 1'b1, "R1", {expiry_flag, irq_n}, 1);
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check(expiry_flag == 1'b0 && irq_n == 1'b1, "R1", {expiry_flag, irq_n}, 1);

    // R4: stopped counter ignores strobes
    preset_lo = 8'd1; src_sel = 2'd0;
    for (int i = 0; i < 4; i++) pulse_src(0);
    cyc(2);
    check(expiry_flag == 1'b0, "R4", expiry_flag, 0);

    // R3: only the selected strobe counts
    preset_lo = 8'd2; src_sel = 2'd2;
    restart();
    pulse_src(0); pulse_src(1); pulse_src(3); pulse_src(3); pulse_src(1);
    cyc(1);
    check(expiry_flag == 1'b0, "R3", expiry_flag, 0);
    measure(2, 5, 1'b0, got);
    check(got == 2, "R3", got, 2);

    // R2: high nibble weights
    preset_hi = 4'd1; preset_lo = 8'd2; src_sel = 2'd0;
    restart();
    measure(0, 300, 1'b0, got);
    check(got == exp_period(4'd1, 8'd2), "R2", got, exp_period(4'd1, 8'd2));
    preset_hi = 4'd0;

    // R6: periodic reload
    preset_lo = 8'd3; src_sel = 2'd1;
    restart();
    measure(1, 10, 1'b0, got);
    clear_flag();
    measure(1, 10, 1'b0, got);
    check(got == 3, "R6", got, 3);
    clear_flag();
    measure(1, 10, 1'b1, got);
    check(got == 3, "R6", got, 3);

    // R5: strobe in the start cycle is not counted
    preset_lo = 8'd1; src_sel = 2'd0;
    run_en = 1'b0; cyc(1); clear_flag();
    run_en = 1'b1; src_stb[0] = 1'b1;
    cyc(1);
    src_stb = '0;
    cyc(2);
    check(expiry_flag == 1'b0, "R5", expiry_flag, 0);
    pulse_src(0); cyc(1);
    check(expiry_flag == 1'b1, "R5", expiry_flag, 1);

    // R7: zero preset
    preset_lo = 8'd0;
    restart();
    for (int i = 0; i < 10; i++) pulse_src(0);
    cyc(2);
    check(expiry_flag == 1'b0, "R7", expiry_flag, 0);

    // R8: clear coinciding with expiry loses, flag is sticky
    preset_lo = 8'd1;
    restart();
    pulse_src(0);
    flag_clr = 1'b1;
    cyc(1);
    flag_clr = 1'b0;
    check(expiry_flag == 1'b1, "R8", expiry_flag, 1);
    cyc(20);
    check(expiry_flag == 1'b1, "R8", expiry_flag, 1);
    clear_flag();
    check(expiry_flag == 1'b0, "R8", expiry_flag, 0);

    // R9 + R11: fast source pulse
    irq_en = 1'b1; preset_lo = 8'd2; src_sel = 2'd0;
    restart();
    pulse_src(0); pulse_src(0);
    check(irq_n == 1'b1, "R9", irq_n, 1);
    cyc(1);
    check(irq_n == 1'b0 && expiry_flag == 1'b1, "R9", {irq_n, expiry_flag}, 1);
    cyc(5);
    check(irq_n == 1'b0, "R11", irq_n, 0);
    pulse_half();
    check(irq_n == 1'b1, "R11", irq_n, 1);
    check(expiry_flag == 1'b1, "R11", expiry_flag, 1);

    // R11: slow source pulse
    preset_lo = 8'd1; src_sel = 2'd2;
    restart();
    pulse_src(2); cyc(1);
    for (int i = 0; i < 63; i++) pulse_half();
    check(irq_n == 1'b0, "R11", irq_n, 0);
    pulse_half();
    check(irq_n == 1'b1, "R11", irq_n, 1);

    // R10: disabled interrupt, and drop mid-pulse
    irq_en = 1'b0;
    restart();
    pulse_src(2); cyc(1);
    check(irq_n == 1'b1 && expiry_flag == 1'b1, "R10", {irq_n, expiry_flag}, 3);
    irq_en = 1'b1;
    restart();
    pulse_src(2); cyc(1);
    check(irq_n == 1'b0, "R10", irq_n, 0);
    irq_en = 1'b0;
    cyc(1);
    check(irq_n == 1'b1, "R10", irq_n, 1);

    // random periods across sources with noise strobes (R2, R3, R6)
    irq_en = 1'b0;
    for (int it = 0; it < 20; it++) begin
      int sel;
      sel = int'($urandom_range(0, 3));
      src_sel = 2'(sel);
      preset_lo = 8'($urandom_range(1, 24));
      restart();
      measure(sel, 40, 1'b1, got);
      check(got == exp_period(4'd0, preset_lo), "R3", got, exp_period(4'd0, preset_lo));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule